// File: doc/BRIEF.md
# Page-Mode Burst Access Sequencer

This block sits between a pipelined 32-bit processor bus and a DRAM controller core. It decides how each processor access reaches the DRAM. An access to the page that is already open runs as a short column-only cycle. An access to a different page closes the row first and then reopens it. The block drives the controller's row address strobe and its access request. It also produces the row and column strobe enables, the processor's next-address signal, and the processor's ready signal. The number of wait states for each kind of cycle is set by parameters. Refresh arbitration is outside the block and reaches it only as a busy input.

A request is captured when the processor's address strobe and the chip select are both high. The same-page flag from the external page comparator and the write flag are stored into a register in the same clock. Every later decision uses only these stored copies. The sequencer has six states:

- `ST_IDLE`: the row is closed.
- `ST_INIT`: initial access, which opens the row.
- `ST_BURST`: a same-page access that follows the previous one back to back.
- `ST_NBURST`: a same-page access that arrives after a gap.
- `ST_OPEN`: the row is held open between accesses.
- `ST_PRECHG`: the row is being closed.

The transitions are:

- `ST_IDLE` to `ST_INIT`: a request is pending and refresh is idle.
- `ST_INIT`, `ST_BURST` or `ST_NBURST` to `ST_OPEN`: the wait count has expired.
- `ST_OPEN` to `ST_BURST`: a request with the page flag set arrives within one cycle of entering the state.
- `ST_OPEN` to `ST_NBURST`: a request with the page flag set arrives later than that.
- `ST_OPEN` to `ST_PRECHG`: refresh becomes busy, or a request arrives with the page flag clear.
- `ST_PRECHG` to `ST_IDLE`: the precharge count has expired.

Top module: `page_burst_seq`

## Requirements
In the latencies below, cycle 0 is the clock cycle in which the processor strobe and chip select are sampled high. The first cycle in which `ready_o` is high is counted from that cycle.
- R1: A synchronous active-high `rst` sets every output low (`ctl_strobe_o`, `ctl_req_o`, `row_active_o`, `col_active_o`, `next_addr_o`, `ready_o`) and closes the row.
- R2: An address strobe with the chip select low is ignored. No request is raised and no ready is returned.
- R3: When the row is closed, an access is an initial access. `ctl_strobe_o` is asserted and `ready_o` rises in cycle INIT_WS+3.
- R4: A same-page access issued in the cycle `ready_o` is high, or earlier, is a burst. `row_active_o` stays high throughout, `ctl_strobe_o` stays low, and a read's ready rises in cycle BURST_WS+3.
- R5: With HEAVY_LOAD=1, a burst write takes one wait state more than a burst read (cycle BURST_WS+4).
- R6: A same-page access issued one or more cycles after the ready cycle is a non-burst. Its ready rises in cycle NBURST_WS+3.
- R7: A request whose stored page flag is clear while the row is open closes the row for PRE_CYC cycles and then runs as an initial access. Its ready rises in cycle PRE_CYC+INIT_WS+4.
- R8: The page flag is stored when the request is captured. A change on `page_hit_i` after that cycle does not affect how the access is classified.
- R9: `ready_o` is a one-cycle pulse. It follows the final cycle of the access, which is the cycle in which `col_active_o` is high, by exactly one clock.
- R10: `next_addr_o` pulses once per access, in the cycle before ready. The exception is an initial access whose stored page flag is set: there it pulses two cycles before ready.
- R11: Refresh busy while the row is open closes the row (`row_active_o` low in the next cycle). While refresh is busy, no new access starts. A pending request starts in the cycle after busy drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_strobe_i | input | 1 | Processor address strobe (valid address present) |
| cpu_sel_i | input | 1 | Chip select decoded for this memory |
| cpu_write_i | input | 1 | 1 = write access, 0 = read access |
| page_hit_i | input | 1 | Same row and bank as the previous access |
| refresh_busy_i | input | 1 | Refresh in progress or pending |
| ctl_strobe_o | output | 1 | Address strobe to the controller; high during an initial access |
| ctl_req_o | output | 1 | Access request to the controller; high while any access runs |
| row_active_o | output | 1 | Row strobe enable; high while the row is open |
| col_active_o | output | 1 | Column strobe enable; high in the final cycle of an access |
| next_addr_o | output | 1 | Next-address request to the processor |
| ready_o | output | 1 | Ready to the processor |

## Verification
The hardest case to reach from the ports is telling a burst apart from a non-burst, because the two differ only in how many idle cycles the row stays open. The bench samples at the falling edge. It issues the next strobe either in the same half-cycle in which it first sees `ready_o`, or exactly one cycle later, and so hits both sides of the boundary. The stored page flag is tested by reversing `page_hit_i` one cycle after capture. The refresh cases hold busy across the precharge and release it while a request is pending, which also produces the early next-address of an initial access with its page flag set.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_NBURST,
        ST_BURST,
        ST_OPEN,
        ST_PRECHG
    } seq_state_e;

endpackage

// File: rtl/pbs_req_stage.sv
// Captures one processor request together with its page and write flags.
module pbs_req_stage (
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    input  logic sel_i,
    input  logic hit_i,
    input  logic wr_i,
    input  logic take_i,
    output logic pend_o,
    output logic hit_o,
    output logic wr_o
);

    logic capture;

    assign capture = strobe_i & sel_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_o <= 1'b0;
            hit_o  <= 1'b0;
            wr_o   <= 1'b0;
        end else begin
            if (capture) begin
                pend_o <= 1'b1;
                hit_o  <= hit_i;
                wr_o   <= wr_i;
            end else if (take_i) begin
                pend_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pbs_wait_timer.sv
// Down-counter shared by access wait states and precharge.
module pbs_wait_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [CW-1:0] val_i,
    output logic [CW-1:0] cnt_o,
    output logic          zero_o
);

    assign zero_o = (cnt_o == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o <= '0;
        end else if (load_i) begin
            cnt_o <= val_i;
        end else if (!zero_o) begin
            cnt_o <= cnt_o - 1'b1;
        end
    end

endmodule

// File: rtl/pbs_gap_meter.sv
// Counts idle cycles spent with the row held open (saturating).
module pbs_gap_meter #(
    parameter int GW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          open_i,
    output logic [GW-1:0] gap_o
);

    localparam logic [GW-1:0] GAP_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_o <= '0;
        end else if (!open_i) begin
            gap_o <= '0;
        end else if (gap_o != GAP_MAX) begin
            gap_o <= gap_o + 1'b1;
        end
    end

endmodule

// File: rtl/pbs_seq_fsm.sv
module pbs_seq_fsm
    import pbs_pkg::*;
#(
    parameter int INIT_WS    = 3,
    parameter int NBURST_WS  = 2,
    parameter int BURST_WS   = 0,
    parameter int HEAVY_LOAD = 1,
    parameter int PRE_CYC    = 2,
    parameter int CW         = 3,
    parameter int GW         = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pend_i,
    input  logic          hit_i,
    input  logic          wr_i,
    input  logic          busy_i,
    input  logic          zero_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [GW-1:0] gap_i,
    output logic          take_o,
    output logic          load_o,
    output logic [CW-1:0] load_val_o,
    output logic          open_o,
    output logic          ctl_strobe_o,
    output logic          ctl_req_o,
    output logic          row_o,
    output logic          col_o,
    output logic          next_addr_o
);

    localparam logic [CW-1:0] LD_INIT   = CW'(INIT_WS);
    localparam logic [CW-1:0] LD_NBURST = CW'(NBURST_WS);
    localparam logic [CW-1:0] LD_BRD    = CW'(BURST_WS);
    localparam logic [CW-1:0] LD_BWR    = CW'(BURST_WS + ((HEAVY_LOAD != 0) ? 1 : 0));
    localparam logic [CW-1:0] LD_PRE    = CW'(PRE_CYC - 1);
    localparam logic [CW-1:0] ONE       = CW'(1);
    localparam bit            EARLY_OK  = (INIT_WS >= 1);
    localparam logic [GW-1:0] GAP_BURST = GW'(1);

    seq_state_e state_q, state_d;
    logic       init_hit_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // page flag of the request that opened the row
    always_ff @(posedge clk) begin
        if (rst) begin
            init_hit_q <= 1'b0;
        end else if (state_q == ST_IDLE && take_o) begin
            init_hit_q <= hit_i;
        end
    end

    // next state and timer control
    always_comb begin
        state_d    = state_q;
        take_o     = 1'b0;
        load_o     = 1'b0;
        load_val_o = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (pend_i && !busy_i) begin
                    state_d    = ST_INIT;
                    take_o     = 1'b1;
                    load_o     = 1'b1;
                    load_val_o = LD_INIT;
                end
            end
            ST_INIT, ST_NBURST, ST_BURST: begin
                if (zero_i) begin
                    state_d = ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (busy_i) begin
                    state_d    = ST_PRECHG;
                    load_o     = 1'b1;
                    load_val_o = LD_PRE;
                end else if (pend_i && hit_i) begin
                    take_o = 1'b1;
                    load_o = 1'b1;
                    if (gap_i <= GAP_BURST) begin
                        state_d    = ST_BURST;
                        load_val_o = wr_i ? LD_BWR : LD_BRD;
                    end else begin
                        state_d    = ST_NBURST;
                        load_val_o = LD_NBURST;
                    end
                end else if (pend_i) begin
                    state_d    = ST_PRECHG;
                    load_o     = 1'b1;
                    load_val_o = LD_PRE;
                end
            end
            ST_PRECHG: begin
                if (zero_i) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ctl_strobe_o = 1'b0;
        ctl_req_o    = 1'b0;
        row_o        = 1'b0;
        col_o        = 1'b0;
        next_addr_o  = 1'b0;
        open_o       = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_PRECHG: begin
            end
            ST_INIT: begin
                ctl_strobe_o = 1'b1;
                ctl_req_o    = 1'b1;
                row_o        = 1'b1;
                col_o        = zero_i;
                if (EARLY_OK && init_hit_q) begin
                    next_addr_o = (cnt_i == ONE);
                end else begin
                    next_addr_o = zero_i;
                end
            end
            ST_NBURST, ST_BURST: begin
                ctl_req_o   = 1'b1;
                row_o       = 1'b1;
                col_o       = zero_i;
                next_addr_o = zero_i;
            end
            ST_OPEN: begin
                row_o  = 1'b1;
                open_o = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/page_burst_seq.sv
module page_burst_seq #(
    parameter int INIT_WS    = 3,
    parameter int NBURST_WS  = 2,
    parameter int BURST_WS   = 0,
    parameter int HEAVY_LOAD = 1,
    parameter int PRE_CYC    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cpu_strobe_i,
    input  logic cpu_sel_i,
    input  logic cpu_write_i,
    input  logic page_hit_i,
    input  logic refresh_busy_i,
    output logic ctl_strobe_o,
    output logic ctl_req_o,
    output logic row_active_o,
    output logic col_active_o,
    output logic next_addr_o,
    output logic ready_o
);

    localparam int M1   = (INIT_WS > NBURST_WS) ? INIT_WS : NBURST_WS;
    localparam int M2   = (M1 > BURST_WS + 1) ? M1 : BURST_WS + 1;
    localparam int MAXW = (M2 > PRE_CYC) ? M2 : PRE_CYC;
    localparam int CW   = $clog2(MAXW + 1);
    localparam int GW   = 2;

    logic          pend, hit_s, wr_s, take;
    logic          load, zero, open_s;
    logic [CW-1:0] load_val, cnt;
    logic [GW-1:0] gap;
    logic          col_s;

    pbs_req_stage u_req (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (cpu_strobe_i),
        .sel_i    (cpu_sel_i),
        .hit_i    (page_hit_i),
        .wr_i     (cpu_write_i),
        .take_i   (take),
        .pend_o   (pend),
        .hit_o    (hit_s),
        .wr_o     (wr_s)
    );

    pbs_wait_timer #(.CW(CW)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .val_i  (load_val),
        .cnt_o  (cnt),
        .zero_o (zero)
    );

    pbs_gap_meter #(.GW(GW)) u_gap (
        .clk    (clk),
        .rst    (rst),
        .open_i (open_s),
        .gap_o  (gap)
    );

    pbs_seq_fsm #(
        .INIT_WS    (INIT_WS),
        .NBURST_WS  (NBURST_WS),
        .BURST_WS   (BURST_WS),
        .HEAVY_LOAD (HEAVY_LOAD),
        .PRE_CYC    (PRE_CYC),
        .CW         (CW),
        .GW         (GW)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .pend_i       (pend),
        .hit_i        (hit_s),
        .wr_i         (wr_s),
        .busy_i       (refresh_busy_i),
        .zero_i       (zero),
        .cnt_i        (cnt),
        .gap_i        (gap),
        .take_o       (take),
        .load_o       (load),
        .load_val_o   (load_val),
        .open_o       (open_s),
        .ctl_strobe_o (ctl_strobe_o),
        .ctl_req_o    (ctl_req_o),
        .row_o        (row_active_o),
        .col_o        (col_s),
        .next_addr_o  (next_addr_o)
    );

    assign col_active_o = col_s;

    // ready is the completion of an access delayed by one clock
    always_ff @(posedge clk) begin
        if (rst) begin
            ready_o <= 1'b0;
        end else begin
            ready_o <= col_s;
        end
    end

endmodule

// File: rtl/pbs_checker.sv
module pbs_checker (
    input logic clk,
    input logic rst,
    input logic refresh_busy_i,
    input logic ctl_strobe_o,
    input logic ctl_req_o,
    input logic row_active_o,
    input logic col_active_o,
    input logic next_addr_o,
    input logic ready_o
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!ctl_strobe_o && !ctl_req_o && !row_active_o && !col_active_o && !next_addr_o && !ready_o));

    p_strobe_from_closed_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_strobe_o) |-> !$past(row_active_o));

    p_col_inside_row_r4: assert property (@(posedge clk) disable iff (rst)
        col_active_o |-> row_active_o);

    p_ready_follows_col_r9: assert property (@(posedge clk) disable iff (rst)
        col_active_o |=> ready_o);

    p_ready_single_r9: assert property (@(posedge clk) disable iff (rst)
        ready_o |=> !ready_o);

    p_no_start_in_refresh_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_req_o) |-> !$past(refresh_busy_i));

endmodule

bind page_burst_seq pbs_checker u_pbs_chk (
    .clk            (clk),
    .rst            (rst),
    .refresh_busy_i (refresh_busy_i),
    .ctl_strobe_o   (ctl_strobe_o),
    .ctl_req_o      (ctl_req_o),
    .row_active_o   (row_active_o),
    .col_active_o   (col_active_o),
    .next_addr_o    (next_addr_o),
    .ready_o        (ready_o)
);

// File: tb/sim_page_burst_seq.sv
`timescale 1ns/1ps
module sim_page_burst_seq;

    localparam int INIT_WS   = 3;
    localparam int NBURST_WS = 2;
    localparam int BURST_WS  = 0;
    localparam int PRE_CYC   = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpu_strobe = 1'b0, cpu_sel = 1'b0, cpu_write = 1'b0;
    logic page_hit = 1'b0, refresh_busy = 1'b0;
    logic ctl_strobe_o, ctl_req_o, row_active_o, col_active_o, next_addr_o, ready_o;

    int total = 0;
    int bad   = 0;
    bit row_fell;

    always #10 clk = ~clk;

    page_burst_seq #(
        .INIT_WS(INIT_WS), .NBURST_WS(NBURST_WS), .BURST_WS(BURST_WS),
        .HEAVY_LOAD(1), .PRE_CYC(PRE_CYC)
    ) u0 (
        .clk(clk), .rst(rst),
        .cpu_strobe_i(cpu_strobe), .cpu_sel_i(cpu_sel), .cpu_write_i(cpu_write),
        .page_hit_i(page_hit), .refresh_busy_i(refresh_busy),
        .ctl_strobe_o(ctl_strobe_o), .ctl_req_o(ctl_req_o),
        .row_active_o(row_active_o), .col_active_o(col_active_o),
        .next_addr_o(next_addr_o), .ready_o(ready_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Drives one request at the current falling edge and follows it to ready.
    task automatic run_access(input bit wr, input bit hit, input bit flip_hit,
                              input int exp_lat, input int exp_na, input bit exp_cs,
                              input string tag);
        int  n = 0;
        int  na = 0;
        bit  cs = 0;
        bit  lastcol = 0;
        bit  colok = 0;
        row_fell   = 0;
        cpu_strobe = 1'b1; cpu_sel = 1'b1; cpu_write = wr; page_hit = hit;
        while (n < 40) begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                cpu_strobe = 1'b0; cpu_sel = 1'b0;
                if (flip_hit) page_hit = !hit;
            end
            if (ctl_strobe_o) cs = 1;
            if (!row_active_o) row_fell = 1;
            if (next_addr_o && na == 0) na = n;
            if (ready_o) begin
                colok = lastcol;
                break;
            end
            lastcol = col_active_o;
        end
        chk(n == exp_lat, tag, "ready latency", n, exp_lat);
        chk(na == exp_na, {tag, "/R10"}, "next-address cycle", na, exp_na);
        chk(cs == exp_cs, tag, "controller strobe seen", int'(cs), int'(exp_cs));
        chk(colok, "R9", "column strobe in cycle before ready", int'(colok), 1);
    endtask

    task automatic t_reset();
        chk(!ctl_strobe_o && !ctl_req_o && !next_addr_o, "R1", "strobes after reset",
            int'({ctl_strobe_o, ctl_req_o, next_addr_o}), 0);
        chk(!row_active_o && !col_active_o && !ready_o, "R1", "row/col/ready after reset",
            int'({row_active_o, col_active_o, ready_o}), 0);
    endtask

    task automatic t_select_ignored();
        bit seen = 0;
        cpu_strobe = 1'b1; cpu_sel = 1'b0;
        @(negedge clk);
        cpu_strobe = 1'b0;
        repeat (8) begin
            @(negedge clk);
            if (ctl_req_o || ready_o || row_active_o) seen = 1;
        end
        chk(!seen, "R2", "activity without chip select", int'(seen), 0);
    endtask

    task automatic t_initial();
        run_access(1'b0, 1'b0, 1'b0, INIT_WS + 3, INIT_WS + 2, 1'b1, "R3");
    endtask

    task automatic t_burst_read();
        run_access(1'b0, 1'b1, 1'b0, BURST_WS + 3, BURST_WS + 2, 1'b0, "R4");
        chk(!row_fell, "R4", "row held through burst", int'(row_fell), 0);
    endtask

    task automatic t_burst_write();
        run_access(1'b1, 1'b1, 1'b0, BURST_WS + 4, BURST_WS + 3, 1'b0, "R5");
        chk(!row_fell, "R5", "row held through burst write", int'(row_fell), 0);
    endtask

    task automatic t_nonburst();
        @(negedge clk);
        chk(!ready_o, "R9", "ready one cycle wide", int'(ready_o), 0);
        chk(row_active_o, "R6", "row open between accesses", int'(row_active_o), 1);
        run_access(1'b0, 1'b1, 1'b0, NBURST_WS + 3, NBURST_WS + 2, 1'b0, "R6");
    endtask

    task automatic t_registered_hit();
        run_access(1'b0, 1'b1, 1'b1, BURST_WS + 3, BURST_WS + 2, 1'b0, "R8");
        chk(!row_fell, "R8", "row not closed by late page change", int'(row_fell), 0);
    endtask

    task automatic t_page_miss();
        run_access(1'b0, 1'b0, 1'b0, PRE_CYC + INIT_WS + 4, PRE_CYC + INIT_WS + 3,
                   1'b1, "R7");
        chk(row_fell, "R7", "row closed on page miss", int'(row_fell), 1);
    endtask

    task automatic t_refresh();
        bit seen = 0;
        int n = 0;
        int na = 0;
        refresh_busy = 1'b1;
        @(negedge clk);
        chk(!row_active_o, "R11", "row closed by refresh", int'(row_active_o), 0);
        repeat (3) @(negedge clk);
        cpu_strobe = 1'b1; cpu_sel = 1'b1; cpu_write = 1'b0; page_hit = 1'b1;
        @(negedge clk);
        cpu_strobe = 1'b0; cpu_sel = 1'b0;
        repeat (4) begin
            @(negedge clk);
            if (ctl_req_o || ready_o) seen = 1;
        end
        chk(!seen, "R11", "access held off during refresh", int'(seen), 0);
        refresh_busy = 1'b0;
        while (n < 40) begin
            @(negedge clk);
            n++;
            if (next_addr_o && na == 0) na = n;
            if (ready_o) break;
        end
        chk(n == INIT_WS + 2, "R11", "start after refresh release", n, INIT_WS + 2);
        chk(na == INIT_WS, "R10", "early next-address on hit in initial", na, INIT_WS);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run hung (all requirements) actual=1 expected=0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_select_ignored();
        t_initial();
        t_burst_read();
        t_burst_write();
        t_nonburst();
        t_registered_hit();
        t_page_miss();
        t_refresh();
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule